// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that counts a slow tick input, nominally 31250 Hz, in a 31-bit free-running counter. A programmable right shift gives a scaled view of that count, and the scaled value is compared with a 16-bit threshold. When the scaled count reaches or passes the threshold, a sticky pending flag is set. That flag drives the interrupt output, and the same event can also raise a single-cycle reset request toward the system reset controller.

Software reaches the block through a simple 32-bit write/read port. Reads are combinational on the address. Every write that changes state must come directly after a write of the unlock word to the key register. Any write at all consumes the unlock. Software restarts the counter by writing a magic word to the feed register while the block is unlocked. Optional settings clear the counter when the threshold is met and gate counting on a core-awake input.

Top module: `wdk_top`

## Requirements
- R1: After reset, config (0x00) reads 0, raw count (0x08) reads 0, compare (0x20) reads 0x0000FFFF, key (0x1C) reads 0, and irq_o and rst_req_o are low.
- R2: A write of 0x0051F15E to offset 0x1C unlocks the block, and the key register then reads 1. The next bus write of any kind relocks it, and the key register then reads 0. Reads do not affect the lock.
- R3: A write to config (0x00), feed (0x18) or compare (0x20) that is not directly preceded by the unlock write is ignored.
- R4: An unlocked write of 0x0D09F00D to feed (0x18) clears the counter. An unlocked feed of any other value leaves the counter unchanged.
- R5: The counter advances by one on each cycle in which tick_i is high and either config bit 12 is set, or config bit 13 is set and awake_i is high. Otherwise it holds.
- R6: Scaled count (0x10) reads the raw count shifted right by config bits [3:0].
- R7: The pending flag (config bit 28, mirrored on irq_o) is set one cycle after the scaled count is at or above compare bits [15:0], and stays set.
- R8: An unlocked config write with bit 28 = 0 clears the pending flag. Writing 1 to bit 28 never sets it.
- R9: With config bit 8 set, rst_req_o pulses high for exactly one cycle at the onset of a compare match. With bit 8 clear, it stays low.
- R10: With config bit 9 set, a compare match clears the counter on the next clock.
- R11: Writes to raw count (0x08) and scaled count (0x10) do not change the counter, but they still consume the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one count per high cycle |
| awake_i | input | 1 | Core-awake qualifier for the awake-only run mode |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 8 | Byte offset for both write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Pending flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume the following about the inputs:
- wr_i is a one-cycle strobe with addr_i and wdata_i stable in that cycle.
- tick_i is a level sampled on each clock.
- awake_i changes only between ticks.

The stimulus changes every input on the falling edge, so each write and each tick covers exactly one rising edge, and every read is taken while no write is active. Match onsets are set up from a known counter value, which is cleared by a feed write before every compare scenario. This way the single reset pulse and the auto-clear land on predictable cycles.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int SCALE_W = 4;

  localparam logic [7:0] OFF_CFG    = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h08;
  localparam logic [7:0] OFF_SCALED = 8'h10;
  localparam logic [7:0] OFF_FEED   = 8'h18;
  localparam logic [7:0] OFF_KEY    = 8'h1C;
  localparam logic [7:0] OFF_CMP    = 8'h20;

  localparam logic [31:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD   = 32'h0D09_F00D;

  localparam int BIT_RST_EN  = 8;
  localparam int BIT_ZERO_EN = 9;
  localparam int BIT_RUN_ALL = 12;
  localparam int BIT_RUN_AWK = 13;
  localparam int BIT_PEND    = 28;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic               rst_en;
    logic               zero_en;
    logic               run_all;
    logic               run_awake;
  } cfg_t;
endpackage

// File: rtl/wdk_lock.sv
module wdk_lock #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  import wdk_pkg::*;

  logic unlocked_q;
  logic key_hit;

  assign key_hit = (addr_i == ADDR_W'(OFF_KEY)) && (wdata_i == DATA_W'(UNLOCK_WORD));

  // any write consumes the unlock; only the key word re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlocked_q <= 1'b0;
    else if (wr_i) unlocked_q <= key_hit;
  end

  assign unlocked_o = unlocked_q;

  // R2
  read_keeps_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(unlocked_q));
  // R2
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != ADDR_W'(OFF_KEY)) |=> !unlocked_q);
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              unlocked_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  scaled_i,
  input  logic              pend_i,
  output wdk_pkg::cfg_t     cfg_o,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              feed_clr_o,
  output logic              pend_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import wdk_pkg::*;

  cfg_t             cfg_q;
  logic [CMP_W-1:0] cmp_q;
  logic             prot_wr, cfg_wr, cmp_wr;

  assign prot_wr    = wr_i && unlocked_i;
  assign cfg_wr     = prot_wr && (addr_i == ADDR_W'(OFF_CFG));
  assign cmp_wr     = prot_wr && (addr_i == ADDR_W'(OFF_CMP));
  assign feed_clr_o = prot_wr && (addr_i == ADDR_W'(OFF_FEED)) && (wdata_i == DATA_W'(FEED_WORD));
  assign pend_clr_o = cfg_wr && !wdata_i[BIT_PEND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= '1;
    end else begin
      if (cfg_wr) begin
        cfg_q.scale     <= wdata_i[SCALE_W-1:0];
        cfg_q.rst_en    <= wdata_i[BIT_RST_EN];
        cfg_q.zero_en   <= wdata_i[BIT_ZERO_EN];
        cfg_q.run_all   <= wdata_i[BIT_RUN_ALL];
        cfg_q.run_awake <= wdata_i[BIT_RUN_AWK];
      end
      if (cmp_wr) cmp_q <= wdata_i[CMP_W-1:0];
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFF_CFG): begin
        rdata_o[SCALE_W-1:0] = cfg_q.scale;
        rdata_o[BIT_RST_EN]  = cfg_q.rst_en;
        rdata_o[BIT_ZERO_EN] = cfg_q.zero_en;
        rdata_o[BIT_RUN_ALL] = cfg_q.run_all;
        rdata_o[BIT_RUN_AWK] = cfg_q.run_awake;
        rdata_o[BIT_PEND]    = pend_i;
      end
      ADDR_W'(OFF_RAW):    rdata_o = DATA_W'(cnt_i);
      ADDR_W'(OFF_SCALED): rdata_o = DATA_W'(scaled_i);
      ADDR_W'(OFF_KEY):    rdata_o = DATA_W'(unlocked_i);
      ADDR_W'(OFF_CMP):    rdata_o = DATA_W'(cmp_q);
      default:             rdata_o = '0;
    endcase
  end

  // R3
  locked_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlocked_i) |=> $stable(cmp_q));
  // R3
  locked_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !unlocked_i) |=> $stable(cfg_q));
  // R3
  locked_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |-> !feed_clr_o && !pend_clr_o);
endmodule

// File: rtl/wdk_core.sv
module wdk_core #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             awake_i,
  input  wdk_pkg::cfg_t    cfg_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             feed_clr_i,
  input  logic             pend_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] scaled_o,
  output logic             pend_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q, scaled;
  logic             run, match, match_q, pend_q, rst_req_q;

  assign run    = tick_i && (cfg_i.run_all || (cfg_i.run_awake && awake_i));
  assign scaled = cnt_q >> cfg_i.scale;
  assign match  = scaled >= CNT_W'(cmp_i);

  // feed beats auto-zero beats counting; wraps at 2**CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (feed_clr_i)                 cnt_q <= '0;
    else if (cfg_i.zero_en && match)     cnt_q <= '0;
    else if (run)                        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      match_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (match)           pend_q <= 1'b1;
      else if (pend_clr_i) pend_q <= 1'b0;
      match_q   <= match;
      rst_req_q <= cfg_i.rst_en && match && !match_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign scaled_o  = scaled;
  assign pend_o    = pend_q;
  assign rst_req_o = rst_req_q;

  // R9
  rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
  // R7
  rst_implies_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |-> pend_q);
  // R7
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !pend_clr_i) |=> pend_q);
  // R4
  feed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_clr_i |=> (cnt_q == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !feed_clr_i && !(cfg_i.zero_en && match)) |=> $stable(cnt_q));
  // R10
  auto_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.zero_en && match) |=> (cnt_q == '0));
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              awake_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdk_pkg::cfg_t    cfg;
  logic [CMP_W-1:0] cmp;
  logic [CNT_W-1:0] cnt, scaled;
  logic             unlocked, feed_clr, pend_clr, pend;

  wdk_lock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lock (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .unlocked_o(unlocked)
  );

  wdk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .unlocked_i(unlocked), .cnt_i(cnt), .scaled_i(scaled), .pend_i(pend),
    .cfg_o(cfg), .cmp_o(cmp), .feed_clr_o(feed_clr), .pend_clr_o(pend_clr),
    .rdata_o
  );

  wdk_core #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .awake_i,
    .cfg_i(cfg), .cmp_i(cmp), .feed_clr_i(feed_clr), .pend_clr_i(pend_clr),
    .cnt_o(cnt), .scaled_o(scaled), .pend_o(pend), .rst_req_o
  );

  assign irq_o = pend;
endmodule

// File: tb/wdk_top_tb.sv
module wdk_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  A_CFG = 8'h00, A_RAW = 8'h08, A_SCL = 8'h10,
                          A_FEED = 8'h18, A_KEY = 8'h1C, A_CMP = 8'h20;
  localparam logic [31:0] KEY = 32'h0051_F15E, FOOD = 32'h0D09_F00D;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, awake = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_req;
  int tests = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdk_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .awake_i(awake),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic unl_wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr(A_KEY, KEY);
    bus_wr(a, d);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(A_CFG, d); check("R1 cfg", d, 32'h0);
    bus_rd(A_RAW, d); check("R1 raw", d, 32'h0);
    bus_rd(A_CMP, d); check("R1 cmp", d, 32'h0000_FFFF);
    bus_rd(A_KEY, d); check("R1 key", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_wr(A_KEY, KEY);
    bus_rd(A_KEY, d); check("R2 unlocked", d, 32'h1);
    bus_rd(A_KEY, d); check("R2 read keeps", d, 32'h1);
    bus_wr(8'h30, 32'h0);
    bus_rd(A_KEY, d); check("R2 relock", d, 32'h0);
    bus_wr(A_KEY, 32'h0051_F15F);
    bus_rd(A_KEY, d); check("R2 wrong key", d, 32'h0);
  endtask

  task automatic t_locked_ignored();
    logic [31:0] d;
    bus_wr(A_CFG, 32'h0000_1000);
    bus_rd(A_CFG, d); check("R3 cfg ignored", d, 32'h0);
    bus_wr(A_CMP, 32'h0000_0005);
    bus_rd(A_CMP, d); check("R3 cmp ignored", d, 32'h0000_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] d;
    unl_wr(A_CFG, 32'h0000_1000);
    ticks(10);
    bus_rd(A_RAW, d); check("R5 run always", d, 32'd10);
    unl_wr(A_CFG, 32'h0000_2000);
    awake = 1'b0; ticks(5);
    bus_rd(A_RAW, d); check("R5 asleep holds", d, 32'd10);
    awake = 1'b1; ticks(3);
    bus_rd(A_RAW, d); check("R5 awake runs", d, 32'd13);
    unl_wr(A_CFG, 32'h0);
    ticks(4);
    bus_rd(A_RAW, d); check("R5 disabled", d, 32'd13);
  endtask

  task automatic t_feed();
    logic [31:0] d;
    unl_wr(A_FEED, 32'h1234_5678);
    bus_rd(A_RAW, d); check("R4 wrong food", d, 32'd13);
    bus_wr(A_FEED, FOOD);
    bus_rd(A_RAW, d); check("R3 locked feed", d, 32'd13);
    unl_wr(A_FEED, FOOD);
    bus_rd(A_RAW, d); check("R4 feed clears", d, 32'd0);
  endtask

  task automatic t_scaled();
    logic [31:0] d;
    unl_wr(A_CFG, 32'h0000_1003);
    ticks(40);
    bus_rd(A_RAW, d); check("R6 raw", d, 32'd40);
    bus_rd(A_SCL, d); check("R6 scaled", d, 32'd5);
  endtask

  task automatic t_ro_regs();
    logic [31:0] d;
    unl_wr(A_RAW, 32'd7);
    bus_rd(A_RAW, d); check("R11 raw ro", d, 32'd40);
    bus_rd(A_KEY, d); check("R11 unlock used", d, 32'h0);
    unl_wr(A_SCL, 32'd9);
    bus_rd(A_SCL, d); check("R11 scaled ro", d, 32'd5);
  endtask

  task automatic t_match_reset();
    logic [31:0] d;
    int p0;
    unl_wr(A_FEED, FOOD);
    unl_wr(A_CMP, 32'd4);
    unl_wr(A_CFG, 32'h0000_1101);
    p0 = pulses;
    ticks(7);
    check("R7 no early irq", {31'b0, irq}, 32'h0);
    ticks(5);
    check("R9 one pulse", pulses - p0, 1);
    check("R7 irq", {31'b0, irq}, 32'h1);
    bus_rd(A_CFG, d); check("R7 pend bit", d, 32'h1000_1101);
    unl_wr(A_CMP, 32'h0000_FFFF);
    check("R7 sticky", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_pend_clear();
    logic [31:0] d;
    unl_wr(A_CFG, 32'h0000_1001);
    check("R8 cleared", {31'b0, irq}, 32'h0);
    unl_wr(A_CFG, 32'h1000_1001);
    bus_rd(A_CFG, d); check("R8 no set", d, 32'h0000_1001);
  endtask

  task automatic t_auto_zero();
    logic [31:0] d;
    int p0;
    unl_wr(A_FEED, FOOD);
    unl_wr(A_CMP, 32'd3);
    unl_wr(A_CFG, 32'h0000_1200);
    p0 = pulses;
    ticks(3);
    bus_rd(A_RAW, d); check("R10 zeroed", d, 32'd0);
    check("R10 irq", {31'b0, irq}, 32'h1);
    check("R9 no pulse w/o enable", pulses - p0, 0);
    ticks(2);
    bus_rd(A_RAW, d); check("R10 recount", d, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_locked_ignored();
    t_count();
    t_feed();
    t_scaled();
    t_ro_regs();
    t_match_reset();
    t_pend_clear();
    t_auto_zero();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule